// File: doc/BRIEF.md
# Sequential Shift-and-Add Unsigned Multiplier

This block multiplies two unsigned WIDTH-bit operands over several clock cycles. It uses one WIDTH-bit adder and a shift register instead of a full array of partial-product adders. A one-cycle `start` pulse loads the multiplicand into a holding register. The same pulse loads the multiplier into the low half of the accumulator and clears the high half. One add-and-shift step then runs on each clock.

In each step, the lowest bit of the multiplier half chooses what the adder adds to the high half: the multiplicand or zero. The adder's carry-out, the sum and the remaining multiplier bits then move right together by one place. The spent multiplier bit drops off the low end, and the product grows in from the top. After WIDTH steps, the full 2·WIDTH-bit product sits in the accumulator. A one-cycle `done` pulse marks this, and the product stays on the `product` port until the next accepted start.

The controller has three states:
- `ST_IDLE` waits for `start`. Transition *accept*: `start` high moves to `ST_RUN` and loads the operands.
- `ST_RUN` performs one step per cycle. Transition *last_step*: when the step counter reaches WIDTH−1, it moves to `ST_DONE`.
- `ST_DONE` raises `done`. Transition *retire*: it always returns to `ST_IDLE` on the next clock.

Top module: `shift_add_mult`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `busy` and `done` are 0 and `product` is all zeros.
- R2: `start` sampled high in the idle state captures `a` (multiplicand) and `b` (multiplier), and `busy` is 1 from the next cycle on.
- R3: `done` is asserted exactly WIDTH clock edges after the edge at which `busy` first goes high, with one add-and-shift step per edge.
- R4: `done` is high for exactly one cycle. `busy` is high during that cycle and falls on the following edge.
- R5: When `done` is high, `product` equals the unsigned product of the captured `a` and `b`, with the high half in bits [2·WIDTH−1:WIDTH].
- R6: While idle and `start` is low, `product` holds its last value.
- R7: `start` while `busy` is high is ignored. It does not change the result, the latency or the operands in use, and the values on `a`/`b` during a run have no effect.
- R8: The corner operands give exact results: a zero operand gives 0, all-ones by all-ones gives (2^WIDTH−1)², and 13 × 11 gives 143.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a multiplication; sampled only when idle |
| a | input | WIDTH | Unsigned multiplicand |
| b | input | WIDTH | Unsigned multiplier |
| busy | output | 1 | High from the cycle after acceptance through the done cycle |
| done | output | 1 | One-cycle pulse: product is valid |
| product | output | 2·WIDTH | Unsigned product, held until the next accepted start |

## Verification
The checker assumes that `start` and the operands change only between clock edges, and that the operands present on an accepted `start` are the ones the result is compared against. The bench drives every input on the falling edge and holds `start` high for one cycle when idle. It also raises `start` with different operands in the middle of a run to show that such a request is dropped. It reads the outputs on falling edges, where the value of every output is settled.

// File: rtl/shmul_pkg.sv
package shmul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } shmul_state_e;

endpackage

// File: rtl/shmul_adder.sv
// Ripple-carry adder built from one full-adder cell per bit.
module shmul_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    logic [WIDTH:0] cy;

    assign cy[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        logic gen_b;
        logic prop_b;
        assign gen_b     = x[i] & y[i];
        assign prop_b    = x[i] ^ y[i];
        assign sum[i]    = prop_b ^ cy[i];
        assign cy[i+1]   = gen_b | (prop_b & cy[i]);
    end

    assign cout = cy[WIDTH];

endmodule

// File: rtl/shmul_datapath.sv
// Multiplicand register plus combined high/low accumulator shifting right.
module shmul_datapath #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [WIDTH-1:0]   mcand_in,
    input  logic [WIDTH-1:0]   mplier_in,
    output logic [2*WIDTH-1:0] acc_out
);

    localparam int PW = 2 * WIDTH;

    logic [WIDTH-1:0] mcand_q;
    logic [WIDTH-1:0] hi_q;
    logic [WIDTH-1:0] lo_q;
    logic [WIDTH-1:0] addend;
    logic [WIDTH-1:0] sum;
    logic             carry;

    // Add/no-add select driven by the current low multiplier bit.
    assign addend = lo_q[0] ? mcand_q : '0;

    shmul_adder #(.WIDTH(WIDTH)) u_adder (
        .x    (hi_q),
        .y    (addend),
        .sum  (sum),
        .cout (carry)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
        end else if (load) begin
            mcand_q <= mcand_in;
            hi_q    <= '0;
            lo_q    <= mplier_in;
        end else if (step) begin
            // {carry, sum, lo} moves right one place; lo[0] is dropped.
            hi_q <= {carry, sum[WIDTH-1:1]};
            lo_q <= {sum[0], lo_q[WIDTH-1:1]};
        end
    end

    assign acc_out = PW'({hi_q, lo_q});

endmodule

// File: rtl/shmul_ctrl.sv
// Sequencer: accepts a request, issues WIDTH steps, then pulses done.
module shmul_ctrl
    import shmul_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);

    localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

    shmul_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // State register and step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (cnt_q == LAST) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the present state.
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_RUN: begin
                step = 1'b1;
                busy = 1'b1;
            end
            ST_DONE: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult #(
    parameter int WIDTH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [WIDTH-1:0]     a,
    input  logic [WIDTH-1:0]     b,
    output logic                 busy,
    output logic                 done,
    output logic [2*WIDTH-1:0]   product
);

    logic load;
    logic step;

    shmul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    shmul_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .mcand_in  (a),
        .mplier_in (b),
        .acc_out   (product)
    );

endmodule

// File: rtl/shift_add_mult_chk.sv
module shift_add_mult_chk #(
    parameter int WIDTH = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [WIDTH-1:0]   a,
    input logic [WIDTH-1:0]   b,
    input logic               busy,
    input logic               done,
    input logic [2*WIDTH-1:0] product
);

    localparam int PW  = 2 * WIDTH;
    localparam int LW  = $clog2(WIDTH + 2);

    logic [PW-1:0] ref_q;
    logic [LW-1:0] lat_q;

    // Reference product captured on each accepted request; run-length counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= '0;
            lat_q <= '0;
        end else begin
            if (start && !busy) begin
                ref_q <= PW'(a) * PW'(b);
            end
            if (busy && !done) begin
                lat_q <= lat_q + 1'b1;
            end else if (!busy) begin
                lat_q <= '0;
            end
        end
    end

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R3
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_q == LW'(WIDTH)));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R4
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R5
    result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (product == ref_q));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));

endmodule

bind shift_add_mult shift_add_mult_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .a       (a),
    .b       (b),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/shift_add_mult_bench.sv
module shift_add_mult_bench;

    localparam int W  = 8;
    localparam int PW = 2 * W;
    localparam int NV = 8;

    // {multiplicand, multiplier}
    localparam logic [2*W-1:0] VEC [NV] = '{
        {8'd13,  8'd11},
        {8'd0,   8'd0},
        {8'd0,   8'd200},
        {8'd177, 8'd0},
        {8'd255, 8'd255},
        {8'd1,   8'd255},
        {8'd128, 8'd2},
        {8'd170, 8'd85}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  a = '0;
    logic [W-1:0]  b = '0;
    logic          busy;
    logic          done;
    logic [PW-1:0] product;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    shift_add_mult #(.WIDTH(W)) u_shift_add_mult (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .a       (a),
        .b       (b),
        .busy    (busy),
        .done    (done),
        .product (product)
    );

    task automatic check(input string req, input logic [PW-1:0] act,
                         input logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Runs one multiply; optionally injects a start with other operands mid-run.
    task automatic run_mul(input logic [W-1:0] x, input logic [W-1:0] y,
                           input bit inject, input string req);
        int lat;
        @(negedge clk);
        a = x; b = y; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        a = ~x; b = ~y;
        check("R2 busy after accept", PW'(busy), PW'(1));
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
            if (inject && lat == 2) begin
                start = 1'b1; a = 8'd3; b = 8'd5;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        check("R3 latency", PW'(lat), PW'(W));
        check(req, product, PW'(x) * PW'(y));
        @(negedge clk);
        check("R4 done one cycle", PW'(done), PW'(0));
        check("R4 busy falls", PW'(busy), PW'(0));
        repeat (3) @(negedge clk);
        check("R6 product held", product, PW'(x) * PW'(y));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy in reset", PW'(busy), PW'(0));
        check("R1 done in reset", PW'(done), PW'(0));
        check("R1 product in reset", product, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after release", PW'(busy), PW'(0));
        check("R1 product after release", product, '0);

        for (int i = 0; i < NV; i++) begin
            run_mul(VEC[i][2*W-1:W], VEC[i][W-1:0], 1'b0, "R5 R8 vector product");
        end

        // R7: start during a run is dropped.
        run_mul(8'd200, 8'd201, 1'b1, "R7 ignored start keeps result");
        @(negedge clk);
        check("R7 no restart after ignored start", PW'(busy), PW'(0));

        // R8: named corners.
        run_mul(8'd13, 8'd11, 1'b0, "R8 13x11");
        run_mul(8'd255, 8'd255, 1'b0, "R8 all ones");
        run_mul(8'd0, 8'd255, 1'b0, "R8 zero multiplicand");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule